// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the target-side control engine of a simplified PCI memory target. It watches the master's FRAME#, IRDY# and LOCK# lines and a command/address pair. It accepts memory reads and memory writes and answers with DEVSEL#, TRDY# and STOP#. Writes go into a small posted-write buffer through a push strobe. Reads take their data from a read source addressed by the current dword address. The block advances that address by one dword on every completed data phase.

The block ends a transaction early in three cases. It retries an address phase that tries to use a locked region while another master owns the lock. It stops a write when the posted-write buffer cannot take another word. It disconnects a read burst at the last dword of a 32-byte line when a line-disconnect enable is set. Each active-low bus line has a separate input or output port, and one enable covers the three target control outputs. A further enable covers the read data lines.

Top module: `pci_tgt_term`

## Requirements
- R1: While reset is low, and on the first clock after it, the target drives nothing: `tgt_oe_o` and `ad_oe_o` are low and DEVSEL#, TRDY# and STOP# read high.
- R2: A clock in the idle state where `frame_n_i` is low is an address phase. If `cmd_i` is 4'b0110 (memory read) or 4'b0111 (memory write) and no lock conflict exists, DEVSEL# goes low in the next cycle. A data phase completes on a clock where both IRDY# and TRDY# are low. Exactly then, `wr_push_o` (write) or `rd_ack_o` (read) is high, and the dword address (from `ad_i` at the address phase) then steps by 4.
- R3: A read holds TRDY# high while `rd_valid_i` is low. While TRDY# is low, `ad_o` carries `rd_data_i` with `ad_oe_o` high. A clock with IRDY# high completes no phase.
- R4: When a data phase completes with FRAME# high and no STOP#, the target releases its outputs in the next cycle.
- R5: Lock ownership is taken by `mst_id_i` at an address phase with LOCK# low when no owner is held. A later address phase with LOCK# low from a different ID is retried: STOP# and DEVSEL# low, TRDY# high, no data moved.
- R6: During a write, `wbuf_full_i` high keeps TRDY# high and drives STOP# low. On the first phase this is a retry; later in a burst it ends the transfer with no further push.
- R7: With `line_disc_en_i` high, a read phase at dword index 7 of a line (address bits [4:2] all ones) drives STOP#, DEVSEL# and TRDY# low once `rd_valid_i` is high, and moves that one word. With the enable low, the burst runs on across the line boundary.
- R8: Any other command at an address phase gives a target abort: STOP# low, DEVSEL# high and TRDY# high until release.
- R9: After STOP# goes low, STOP# stays low, and DEVSEL# keeps its value, until FRAME# is sampled high. The outputs are released in the following cycle. A master delay of one to three clocks is tolerated.
- R10: A clock with FRAME# and LOCK# both high clears the lock owner, so another master can then lock and proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n_i | input | 1 | FRAME# from the master |
| irdy_n_i | input | 1 | IRDY# from the master |
| lock_n_i | input | 1 | LOCK# from the master |
| cmd_i | input | 4 | Bus command at the address phase |
| ad_i | input | 32 | Address at the address phase, write data afterwards |
| mst_id_i | input | ID_W | ID of the granted master |
| line_disc_en_i | input | 1 | Enables the read disconnect at line end |
| wbuf_full_i | input | 1 | Posted-write buffer cannot take a word |
| rd_valid_i | input | 1 | Read source has data for `rd_addr_o` |
| rd_data_i | input | 32 | Read source data |
| tgt_oe_o | output | 1 | Enable for DEVSEL#, TRDY# and STOP# |
| devsel_n_o | output | 1 | DEVSEL# |
| trdy_n_o | output | 1 | TRDY# |
| stop_n_o | output | 1 | STOP# |
| ad_oe_o | output | 1 | Enable for read data on the AD lines |
| ad_o | output | 32 | Read data toward the AD lines |
| wr_push_o | output | 1 | Write word accepted this cycle |
| wr_addr_o | output | 32 | Address of the pushed word |
| wr_data_o | output | 32 | Data of the pushed word |
| rd_ack_o | output | 1 | Read word delivered this cycle |
| rd_addr_o | output | 32 | Current read dword address |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the line-end disconnect and a master wait state. A read starts at dword index 7 with the enable set while the master holds IRDY# high in the first data cycle. STOP# and TRDY# must then stay low through the wait, and exactly one word must move once IRDY# falls. The second pair is a lock conflict and a full write buffer at the same address phase: the outcome must be a clean retry with no push. A behavioural reference model in the bench predicts every output on every clock, and directed checks judge the phase count and the termination code of each transaction.

// File: rtl/pci_tgt_pkg.sv
// Package: shared state encoding and bus command codes for the target.
package pci_tgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TERM = 2'd2
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pci_lock_track.sv
// Module: pci_lock_track
// Records which master owns the target's lock and flags a conflicting
// locked address phase. Assumes a single locked region covers the target.
module pci_lock_track #(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_phase,
    input  logic            frame_n_i,
    input  logic            lock_n_i,
    input  logic [ID_W-1:0] mst_id_i,
    output logic            conflict
);
    logic            own_vld_q;
    logic [ID_W-1:0] own_id_q;

    // Flag a locked address phase from a master other than the owner.
    always_comb begin
        conflict = addr_phase && !lock_n_i && own_vld_q && (mst_id_i != own_id_q);
    end

    // Take ownership on a free locked address phase, drop it when bus and lock idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_vld_q <= 1'b0;
            own_id_q  <= '0;
        end else if (frame_n_i && lock_n_i) begin
            own_vld_q <= 1'b0;
        end else if (addr_phase && !lock_n_i && !own_vld_q) begin
            own_vld_q <= 1'b1;
            own_id_q  <= mst_id_i;
        end
    end

    p_lock_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n_i && lock_n_i) |=> !own_vld_q);
    p_lock_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !lock_n_i && !own_vld_q) |=> (own_vld_q && own_id_q == $past(mst_id_i)));
endmodule

// File: rtl/pci_term_policy.sv
// Module: pci_term_policy
// Decides readiness and stop request for the current data phase from the
// direction, buffer state, read data state and line position.
// Assumes the read source keeps rd_valid high until the word is taken.
module pci_term_policy (
    input  logic is_wr,
    input  logic line_last,
    input  logic line_disc_en,
    input  logic wbuf_full,
    input  logic rd_valid,
    output logic ready,
    output logic stop_req
);
    // Writes stall into a stop when the buffer is full; reads stop at line end.
    always_comb begin
        if (is_wr) begin
            ready    = !wbuf_full;
            stop_req = wbuf_full;
        end else begin
            ready    = rd_valid;
            stop_req = line_disc_en && line_last && rd_valid;
        end
    end
endmodule

// File: rtl/pci_tgt_term.sv
// Module: pci_tgt_term
// PCI memory target control: address/data phase sequencing, wait states,
// and early termination (retry, disconnect, target abort).
// Assumes the master deasserts FRAME# within three clocks of seeing STOP#
// and obeys the FRAME#/IRDY# ordering rules; no parity or turnaround.
module pci_tgt_term
    import pci_tgt_pkg::*;
#(
    parameter int ID_W       = 2,
    parameter int LINE_IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n_i,
    input  logic            irdy_n_i,
    input  logic            lock_n_i,
    input  logic [3:0]      cmd_i,
    input  logic [31:0]     ad_i,
    input  logic [ID_W-1:0] mst_id_i,
    input  logic            line_disc_en_i,
    input  logic            wbuf_full_i,
    input  logic            rd_valid_i,
    input  logic [31:0]     rd_data_i,
    output logic            tgt_oe_o,
    output logic            devsel_n_o,
    output logic            trdy_n_o,
    output logic            stop_n_o,
    output logic            ad_oe_o,
    output logic [31:0]     ad_o,
    output logic            wr_push_o,
    output logic [31:0]     wr_addr_o,
    output logic [31:0]     wr_data_o,
    output logic            rd_ack_o,
    output logic [31:0]     rd_addr_o
);
    localparam int IDX_HI = LINE_IDX_W + 1;

    tgt_state_e  state_q, state_d;
    logic        is_wr_q, abort_q;
    logic [31:0] ptr_q;
    logic        addr_phase, cmd_ok, conflict;
    logic        ready, stop_req, line_last;
    logic        in_data, in_term;
    logic        trdy_a, stop_a, devsel_a, xfer, leave;

    assign addr_phase = (state_q == ST_IDLE) && !frame_n_i;
    assign cmd_ok     = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
    assign line_last  = &ptr_q[IDX_HI:2];
    assign in_data    = (state_q == ST_DATA);
    assign in_term    = (state_q == ST_TERM);

    pci_lock_track #(.ID_W(ID_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (addr_phase),
        .frame_n_i  (frame_n_i),
        .lock_n_i   (lock_n_i),
        .mst_id_i   (mst_id_i),
        .conflict   (conflict)
    );

    pci_term_policy u_policy (
        .is_wr        (is_wr_q),
        .line_last    (line_last),
        .line_disc_en (line_disc_en_i),
        .wbuf_full    (wbuf_full_i),
        .rd_valid     (rd_valid_i),
        .ready        (ready),
        .stop_req     (stop_req)
    );

    // Form the active-high control levels for this cycle.
    always_comb begin
        trdy_a   = in_data && ready;
        stop_a   = (in_data && stop_req) || in_term;
        devsel_a = in_data || (in_term && !abort_q);
        xfer     = trdy_a && !irdy_n_i;
        leave    = in_data && stop_req && (!ready || !irdy_n_i);
    end

    // Next-state selection for the phase sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (addr_phase) state_d = (!cmd_ok || conflict) ? ST_TERM : ST_DATA;
            ST_DATA: begin
                if (leave)                  state_d = frame_n_i ? ST_IDLE : ST_TERM;
                else if (xfer && frame_n_i) state_d = ST_IDLE;
            end
            ST_TERM: if (frame_n_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state, transaction attributes and the dword pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_wr_q <= 1'b0;
            abort_q <= 1'b0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (addr_phase) begin
                is_wr_q <= (cmd_i == CMD_MEM_WR);
                abort_q <= !cmd_ok;
                ptr_q   <= ad_i;
            end else if (xfer) begin
                ptr_q <= ptr_q + 32'd4;
            end
        end
    end

    // Drive the bus-facing and buffer-facing outputs.
    always_comb begin
        tgt_oe_o   = (state_q != ST_IDLE);
        devsel_n_o = !devsel_a;
        trdy_n_o   = !trdy_a;
        stop_n_o   = !stop_a;
        ad_oe_o    = in_data && !is_wr_q;
        ad_o       = rd_data_i;
        wr_push_o  = xfer && is_wr_q;
        wr_addr_o  = ptr_q;
        wr_data_o  = ad_i;
        rd_ack_o   = xfer && !is_wr_q;
        rd_addr_o  = ptr_q;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!tgt_oe_o && !ad_oe_o));
    p_trdy_with_devsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_oe_o && !trdy_n_o) |-> !devsel_n_o);
    p_move_on_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_push_o || rd_ack_o) |-> (!irdy_n_i && !trdy_n_o));
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_push_o || rd_ack_o) |=> (ptr_q == $past(ptr_q) + 32'd4));
    p_final_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_push_o || rd_ack_o) && frame_n_i && stop_n_o) |=> !tgt_oe_o);
    p_conflict_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && cmd_ok) |=> (!stop_n_o && !devsel_n_o && trdy_n_o));
    p_abort_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n_o && devsel_n_o) |-> (trdy_n_o && !wr_push_o && !rd_ack_o));
    p_stop_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_term && !frame_n_i) |=> (!stop_n_o && $stable(devsel_n_o)));
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_term && frame_n_i) |=> !tgt_oe_o);
endmodule

// File: tb/pci_tgt_term_test.sv
module pci_tgt_term_test;
    localparam int ID_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_n = 1'b1, irdy_n = 1'b1, lock_n = 1'b1;
    logic [3:0]      cmd_b = 4'h0;
    logic [31:0]     ad = '0;
    logic [ID_W-1:0] mid = '0;
    logic            line_en = 1'b0, wbuf_full = 1'b0, rd_valid = 1'b1;
    logic [31:0]     rd_data;
    logic            tgt_oe_o, devsel_n_o, trdy_n_o, stop_n_o, ad_oe_o;
    logic [31:0]     ad_o, wr_addr_o, wr_data_o, rd_addr_o;
    logic            wr_push_o, rd_ack_o;

    int   n_chk = 0, n_fail = 0, cyc_cnt = 0, tick = 0, fill = 0, cap = 0;
    bit   cap_on = 0, force_full = 0, rd_gap = 0, started = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    assign rd_data = {rd_addr_o[31:2], 2'b11};

    pci_tgt_term #(.ID_W(ID_W), .LINE_IDX_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
        .lock_n_i(lock_n), .cmd_i(cmd_b), .ad_i(ad), .mst_id_i(mid),
        .line_disc_en_i(line_en), .wbuf_full_i(wbuf_full), .rd_valid_i(rd_valid),
        .rd_data_i(rd_data), .tgt_oe_o(tgt_oe_o), .devsel_n_o(devsel_n_o),
        .trdy_n_o(trdy_n_o), .stop_n_o(stop_n_o), .ad_oe_o(ad_oe_o), .ad_o(ad_o),
        .wr_push_o(wr_push_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .rd_ack_o(rd_ack_o), .rd_addr_o(rd_addr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 data, 2 terminating
    int          m_st = 0;
    bit          m_wr = 0, m_ab = 0, m_ov = 0;
    logic [31:0] m_ptr = '0;
    logic [ID_W-1:0] m_oid = '0;
    bit          e_rdy, e_stp, e_x;

    always @(negedge clk) begin
        bit e_oe, e_dev, e_tr, e_sp, e_push, e_ack, ok;
        e_rdy = m_wr ? !wbuf_full : rd_valid;
        e_stp = m_wr ? wbuf_full : (line_en && (m_ptr[4:2] == 3'd7) && rd_valid);
        e_oe  = (m_st != 0);
        e_tr  = (m_st == 1) && e_rdy;
        e_sp  = ((m_st == 1) && e_stp) || (m_st == 2);
        e_dev = (m_st == 1) || ((m_st == 2) && !m_ab);
        e_x   = e_tr && !irdy_n;
        e_push = e_x && m_wr;
        e_ack  = e_x && !m_wr;
        if (started) begin
            ok = (tgt_oe_o == e_oe) && (devsel_n_o == !e_dev) && (trdy_n_o == !e_tr)
              && (stop_n_o == !e_sp) && (wr_push_o == e_push) && (rd_ack_o == e_ack)
              && (ad_oe_o == ((m_st == 1) && !m_wr));
            if (e_push) ok = ok && (wr_addr_o == m_ptr) && (wr_data_o == ad);
            if (e_ack)  ok = ok && (rd_addr_o == m_ptr);
            if (ad_oe_o) ok = ok && (ad_o == {m_ptr[31:2], 2'b11});
            chk(ok, cur_req, {tgt_oe_o, devsel_n_o, trdy_n_o, stop_n_o, wr_push_o, rd_ack_o},
                {e_oe, !e_dev, !e_tr, !e_sp, e_push, e_ack});
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_wr = 0; m_ab = 0; m_ov = 0; m_ptr = '0; m_oid = '0;
        end else begin
            started = 1;
            if (e_x && m_wr) fill++;
            case (m_st)
                0: if (!frame_n) begin
                    bit cok, conf;
                    cok  = (cmd_b == 4'b0110) || (cmd_b == 4'b0111);
                    conf = !lock_n && m_ov && (mid != m_oid);
                    m_ptr = ad; m_wr = (cmd_b == 4'b0111); m_ab = !cok;
                    m_st = (!cok || conf) ? 2 : 1;
                    if (!lock_n && !m_ov) begin m_ov = 1; m_oid = mid; end
                end
                1: begin
                    if (e_stp && (!e_rdy || !irdy_n)) m_st = frame_n ? 0 : 2;
                    else if (e_x && frame_n) m_st = 0;
                    if (e_x) m_ptr = m_ptr + 32'd4;
                end
                default: if (frame_n) m_st = 0;
            endcase
            if (frame_n && lock_n) m_ov = 0;
        end
    end

    // Side stimulus: read-data gaps and write-buffer occupancy
    always begin
        @(posedge clk); #1;
        tick++;
        rd_valid  = !rd_gap || (tick % 3 != 1);
        wbuf_full = force_full || (cap_on && fill >= cap);
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input logic [ID_W-1:0] id,
                        input int nph, input int w, input int lag,
                        output int done, output bit stopped, output logic sd, output logic st);
        int cyc;
        bit fin;
        logic tr, sp;
        done = 0; stopped = 0; sd = 1; st = 1; cyc = 0; fin = 0;
        frame_n = 0; irdy_n = 1; cmd_b = cmd; ad = addr; mid = id;
        @(posedge clk); #1;
        forever begin
            if (!fin) irdy_n = (w > 1) && (cyc % w == 0);
            else irdy_n = 0;
            if (!irdy_n && done == nph - 1) fin = 1;
            frame_n = fin;
            ad = 32'hD000_0000 + done;
            @(negedge clk);
            tr = trdy_n_o; sp = stop_n_o;
            if (!sp) begin sd = devsel_n_o; st = tr; end
            @(posedge clk);
            if (!irdy_n && !tr) done++;
            if (!sp) begin stopped = 1; break; end
            if (fin && !irdy_n && !tr) break;
            #1; cyc++;
        end
        if (stopped && !frame_n) begin
            for (int k = 1; k <= lag; k++) begin
                #1;
                if (k < lag) begin irdy_n = 1; frame_n = 0; end
                else begin irdy_n = 0; frame_n = 1; end
                @(negedge clk); tr = trdy_n_o;
                @(posedge clk);
                if (!irdy_n && !tr) done++;
            end
        end
        #1; frame_n = 1; irdy_n = 1; ad = '0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        int d; bit s; logic sd, st;
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        @(negedge clk);
        chk(!tgt_oe_o && stop_n_o && devsel_n_o && trdy_n_o && !ad_oe_o, "R1", tgt_oe_o, 0);
        @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #1;

        cur_req = "R2";
        xact(4'b0111, 32'h0000_0100, 2'd0, 4, 0, 1, d, s, sd, st);
        chk(d == 4 && !s, "R2 zero-wait write burst", d, 4);

        cur_req = "R3"; rd_gap = 1;
        xact(4'b0110, 32'h0000_001C, 2'd0, 5, 2, 1, d, s, sd, st);
        chk(d == 5 && !s, "R3 read with waits", d, 5);
        chk(!s, "R7 no disconnect when enable low", s, 0);
        rd_gap = 0;

        cur_req = "R7"; line_en = 1;
        xact(4'b0110, 32'h0000_0014, 2'd1, 6, 0, 2, d, s, sd, st);
        chk(d == 3, "R7 line-end disconnect count", d, 3);
        chk(s && !sd && !st, "R7 disconnect code", {sd, st}, 0);

        cur_req = "R9";
        xact(4'b0110, 32'h0000_003C, 2'd1, 4, 2, 2, d, s, sd, st);
        chk(d == 1 && s && !sd && !st, "R9 disconnect across IRDY wait", d, 1);
        line_en = 0;

        cur_req = "R6"; force_full = 1;
        @(posedge clk); #1;
        xact(4'b0111, 32'h0000_0200, 2'd0, 3, 0, 3, d, s, sd, st);
        chk(d == 0 && s && !sd && st, "R6 retry on full buffer", {d, sd, st}, 1);
        force_full = 0;

        fill = 0; cap = 2; cap_on = 1;
        @(posedge clk); #1;
        xact(4'b0111, 32'h0000_0300, 2'd0, 5, 0, 1, d, s, sd, st);
        chk(d == 2 && s && st, "R6 stop mid-burst on full", d, 2);
        cap_on = 0;
        @(posedge clk); #1;

        cur_req = "R5"; lock_n = 0;
        xact(4'b0110, 32'h0000_0040, 2'd1, 2, 0, 1, d, s, sd, st);
        chk(d == 2 && !s, "R5 owner takes lock", d, 2);
        xact(4'b0111, 32'h0000_0048, 2'd1, 2, 0, 1, d, s, sd, st);
        chk(d == 2 && !s, "R5 owner re-enters", d, 2);
        xact(4'b0110, 32'h0000_0040, 2'd2, 2, 0, 2, d, s, sd, st);
        chk(d == 0 && s && !sd && st, "R5 conflict retry", {d, sd, st}, 1);
        force_full = 1;
        @(posedge clk); #1;
        xact(4'b0111, 32'h0000_0040, 2'd3, 2, 0, 1, d, s, sd, st);
        chk(d == 0 && s && !sd && st, "R5 conflict with full buffer", {d, sd, st}, 1);
        force_full = 0;

        cur_req = "R10"; lock_n = 1;
        repeat (2) @(posedge clk);
        #1; lock_n = 0;
        xact(4'b0110, 32'h0000_0040, 2'd2, 2, 0, 1, d, s, sd, st);
        chk(d == 2 && !s, "R10 lock freed for other master", d, 2);
        lock_n = 1;

        cur_req = "R8";
        xact(4'b0010, 32'h0000_0500, 2'd0, 2, 0, 1, d, s, sd, st);
        chk(d == 0 && s && sd && st, "R8 target abort code", {sd, st}, 3);
        xact(4'b1100, 32'h0000_0500, 2'd0, 1, 0, 3, d, s, sd, st);
        chk(d == 0 && s && sd, "R8 abort single phase", d, 0);

        cur_req = "R4";
        xact(4'b0111, 32'h0000_0600, 2'd0, 1, 0, 1, d, s, sd, st);
        chk(d == 1 && !s, "R4 single-phase write", d, 1);
        @(negedge clk);
        chk(!tgt_oe_o, "R4 released after final phase", tgt_oe_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule